// File: doc/BRIEF.md
# Interlaced Video Field Capture and 4:2:0 Downsampler

This block sits between a digital video decoder and a frame buffer. It takes an interlaced byte stream that carries embedded timing codes and active samples in the order Cb, Y, Cr, Y. On a request from the encoder side it waits for a whole bottom field, crops a centred window from it and writes one progressive frame into a word-addressed memory. Luma, Cb and Cr go to three separate, non-overlapping regions.

Vertical chroma reduction to 4:2:0 averages each even/odd pair of window lines, rounding up. The first line of each pair is held in a per-component line buffer until its partner line arrives. The default sizes take a 768-sample, 288-line field and produce a 320x240 frame. All sizes are parameters, so a small configuration can be swept in full.

Top module: `vcap_downsampler`

## Requirements
- R1: After reset `mem_we` and `frame_done` are low, and no write happens until a capture has been requested.
- R2: `cap_req` is accepted only while the block is idle. A request made while a capture is pending or running is ignored, and no write happens after `frame_done` unless a new request is accepted.
- R3: After an accepted request the block first waits for a timing code whose field bit is 0 (top field). It then captures the next bottom field (field bit 1) from its first active line. A bottom field already in progress when the request arrives is never captured.
- R4: A timing code is the byte run FF, 00, 00, XY. In XY, bit 6 is the field bit (1 = bottom), bit 5 is the blanking bit (1 = vertical blanking) and bit 4 is the end bit (0 = start of active samples). After a start code come 2*ACT_PIX active bytes in the order Cb, Y, Cr, Y. Lines whose start code has bit 5 set are neither counted nor captured.
- R5: Active field lines V0 to V0+OUT_H-1 are kept, where V0 = (FIELD_LINES-OUT_H)/2 and lines are numbered from 0.
- R6: Within a kept line, luma samples H0 to H0+OUT_W-1 are kept, with H0 = (ACT_PIX-OUT_W)/2. Chroma samples H0/2 to H0/2+OUT_W/2-1 of each component are kept.
- R7: Kept luma sample x of output row r is written to address r*OUT_W + (x-H0).
- R8: For each output row pair 2k and 2k+1, chroma sample c is written once per component as (a+b+1)>>1, where a is from row 2k and b from row 2k+1. Cb goes to OUT_W*OUT_H + k*OUT_W/2 + c, and Cr to the same offset plus OUT_W*OUT_H/4.
- R9: One capture writes every address from 0 to OUT_W*OUT_H*3/2-1 exactly once and no other address. `frame_done` is a one-cycle pulse that coincides with the write of the last luma sample.
- R10: Each write appears on the memory port in the clock cycle after the input byte it derives from is sampled, and at most one write occurs per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, one stream byte per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_byte | input | 8 | Interlaced stream byte with embedded timing codes |
| cap_req | input | 1 | Request to capture one frame |
| mem_we | output | 1 | Frame memory write strobe |
| mem_addr | output | ADDR_W | Frame memory word address |
| mem_data | output | 8 | Frame memory write data |
| frame_done | output | 1 | One-cycle pulse on the final luma write |

## Verification
On every cycle the assertions check four things. Addresses stay inside the frame. The done pulse is a single cycle, lands on the last luma address and leaves the block idle. No write ever issues outside a running capture. The bench alone can show which field and which window are taken, that chroma averages round up and reach the right plane, and that each address is written exactly once. It can also show that requests are ignored while busy and that the write comes one byte after its source. It does this by comparing the whole memory image against values computed from a generated sample pattern.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_TOP,
        ST_WAIT_BOT,
        ST_CAPT
    } cap_st_e;

    // rounded-up mean of two samples
    function automatic logic [7:0] avg_up(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b} + 9'd1;
        return s[8:1];
    endfunction

endpackage

// File: rtl/vcap_timing.sv
module vcap_timing #(
    parameter int ACT_PIX = 768
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [7:0]                        byte_i,
    output logic                              code_stb,
    output logic                              code_f,
    output logic                              code_v,
    output logic                              code_h,
    output logic                              act_stb,
    output logic [$clog2(2*ACT_PIX)-1:0]      act_idx,
    output logic                              act_f,
    output logic                              act_v
);
    localparam int ACT_BYTES = 2 * ACT_PIX;
    localparam int IW        = $clog2(ACT_BYTES);

    typedef struct packed {
        logic [7:0]    h2;
        logic [7:0]    h1;
        logic [7:0]    h0;
        logic          active;
        logic [IW-1:0] idx;
        logic          f;
        logic          v;
    } tim_t;

    localparam tim_t TIM_RST = '{h2: '0, h1: '0, h0: '0, active: 1'b0,
                                 idx: '0, f: 1'b0, v: 1'b0};

    tim_t q, d;
    logic hit;

    always_comb begin
        d    = q;
        hit  = (q.h2 == 8'hFF) && (q.h1 == 8'h00) && (q.h0 == 8'h00) && byte_i[7];
        d.h2 = q.h1;
        d.h1 = q.h0;
        d.h0 = byte_i;
        if (hit) begin
            d.active = !byte_i[4];
            d.idx    = '0;
            d.f      = byte_i[6];
            d.v      = byte_i[5];
        end else if (q.active) begin
            if (q.idx == IW'(ACT_BYTES - 1)) begin
                d.active = 1'b0;
            end
            d.idx = q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= TIM_RST;
        end else begin
            q <= d;
        end
    end

    assign code_stb = hit;
    assign code_f   = byte_i[6];
    assign code_v   = byte_i[5];
    assign code_h   = byte_i[4];
    assign act_stb  = q.active;
    assign act_idx  = q.idx;
    assign act_f    = q.f;
    assign act_v    = q.v;

endmodule

// File: rtl/vcap_linebuf.sv
module vcap_linebuf #(
    parameter int DEPTH = 160,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/vcap_downsampler.sv
module vcap_downsampler
    import vcap_pkg::*;
#(
    parameter int ACT_PIX     = 768,
    parameter int FIELD_LINES = 288,
    parameter int OUT_W       = 320,
    parameter int OUT_H       = 240,
    parameter int ADDR_W      = $clog2(OUT_W * OUT_H * 3 / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        vid_byte,
    input  logic              cap_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              frame_done
);
    localparam int H0      = (ACT_PIX - OUT_W) / 2;
    localparam int V0      = (FIELD_LINES - OUT_H) / 2;
    localparam int CW      = OUT_W / 2;
    localparam int Y_SIZE  = OUT_W * OUT_H;
    localparam int C_SIZE  = CW * (OUT_H / 2);
    localparam int CB_BASE = Y_SIZE;
    localparam int CR_BASE = Y_SIZE + C_SIZE;
    localparam int TOTAL   = Y_SIZE + 2 * C_SIZE;
    localparam int IW      = $clog2(2 * ACT_PIX);
    localparam int LW      = $clog2(FIELD_LINES);
    localparam int CAW     = $clog2(CW);

    typedef struct packed {
        cap_st_e           st;
        logic [LW-1:0]     line;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              done;
    } cap_t;

    localparam cap_t CAP_RST = '{st: ST_IDLE, line: '0, we: 1'b0,
                                 addr: '0, data: '0, done: 1'b0};

    logic          code_stb, code_f, code_v, code_h;
    logic          act_stb, act_f, act_v;
    logic [IW-1:0] act_idx;
    logic [1:0]    lb_we;
    logic [CAW-1:0] lb_addr;
    logic [7:0]    lb_rd [2];
    cap_t          q, d;
    cap_st_e       st_now;

    int   row, lx, cx;
    logic take, luma_hit, chroma_hit, is_cr, sav_bot;
    logic [7:0] chroma_avg;

    vcap_timing #(.ACT_PIX(ACT_PIX)) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_i   (vid_byte),
        .code_stb (code_stb),
        .code_f   (code_f),
        .code_v   (code_v),
        .code_h   (code_h),
        .act_stb  (act_stb),
        .act_idx  (act_idx),
        .act_f    (act_f),
        .act_v    (act_v)
    );

    assign lb_addr = CAW'(int'(act_idx) / 4 - H0 / 2);

    // one line buffer per chroma component: index 0 Cb, 1 Cr
    for (genvar c = 0; c < 2; c++) begin : g_lb
        vcap_linebuf #(.DEPTH(CW), .DW(8)) u_lb (
            .clk   (clk),
            .we    (lb_we[c]),
            .addr  (lb_addr),
            .wdata (vid_byte),
            .rdata (lb_rd[c])
        );
    end

    always_comb begin
        d          = q;
        d.we       = 1'b0;
        d.done     = 1'b0;
        lb_we      = '0;
        row        = int'(q.line) - V0;
        lx         = int'(act_idx) / 2;
        cx         = int'(act_idx) / 4;
        is_cr      = act_idx[1];
        take       = (q.st == ST_CAPT) && act_stb && act_f && !act_v &&
                     (row >= 0) && (row < OUT_H);
        luma_hit   = take && act_idx[0] && (lx >= H0) && (lx < H0 + OUT_W);
        chroma_hit = take && !act_idx[0] && (cx >= H0 / 2) && (cx < H0 / 2 + CW);
        chroma_avg = avg_up(lb_rd[is_cr], vid_byte);
        sav_bot    = code_stb && code_f && !code_v && !code_h;

        case (q.st)
            ST_IDLE: begin
                if (cap_req) begin
                    d.st = ST_WAIT_TOP;
                end
            end
            ST_WAIT_TOP: begin
                if (code_stb && !code_f) begin
                    d.st = ST_WAIT_BOT;
                end
            end
            ST_WAIT_BOT: begin
                if (sav_bot) begin
                    d.st   = ST_CAPT;
                    d.line = '0;
                end
            end
            default: begin
                if (sav_bot) begin
                    d.line = q.line + 1'b1;
                end
                if (luma_hit) begin
                    d.we   = 1'b1;
                    d.addr = ADDR_W'(row * OUT_W + lx - H0);
                    d.data = vid_byte;
                    if ((row == OUT_H - 1) && (lx == H0 + OUT_W - 1)) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end
                end else if (chroma_hit) begin
                    if ((row % 2) == 0) begin
                        lb_we[is_cr] = 1'b1;
                    end else begin
                        d.we   = 1'b1;
                        d.addr = ADDR_W'((is_cr ? CR_BASE : CB_BASE) +
                                         (row / 2) * CW + cx - H0 / 2);
                        d.data = chroma_avg;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CAP_RST;
        end else begin
            q <= d;
        end
    end

    assign mem_we     = q.we;
    assign mem_addr   = q.addr;
    assign mem_data   = q.data;
    assign frame_done = q.done;
    assign st_now     = q.st;

endmodule

// File: rtl/vcap_sva.sv
module vcap_sva
    import vcap_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int TOTAL  = 48,
    parameter int LAST_Y = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              frame_done,
    input cap_st_e           st
);
    AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_addr) < TOTAL)); // R7

    AST_DONE_ON_LAST_LUMA: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (mem_we && (int'(mem_addr) == LAST_Y))); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R9

    AST_DONE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (st == ST_IDLE)); // R2

    AST_NO_WRITE_OFF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_CAPT) |=> !mem_we); // R1

endmodule

bind vcap_downsampler vcap_sva #(
    .ADDR_W (ADDR_W),
    .TOTAL  (TOTAL),
    .LAST_Y (Y_SIZE - 1)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .frame_done (frame_done),
    .st         (st_now)
);

// File: tb/vcap_downsampler_tb.sv
module vcap_downsampler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ACT = 16;
    localparam int FL  = 8;
    localparam int W   = 8;
    localparam int H   = 4;
    localparam int H0  = (ACT - W) / 2;
    localparam int V0  = (FL - H) / 2;
    localparam int CW  = W / 2;
    localparam int YS  = W * H;
    localparam int CS  = CW * (H / 2);
    localparam int TOT = YS + 2 * CS;
    localparam int AW  = $clog2(TOT);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    vid_byte = 8'h10;
    logic          cap_req = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;
    logic          frame_done;

    int checks = 0;
    int errors = 0;
    int byte_num = 0;
    int last_byte = -1;
    int done_at = -1;
    int done_cnt = 0;
    int wr_cnt = 0;
    int bad_addr = 0;
    int got  [TOT];
    int hits [TOT];
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vcap_downsampler #(.ACT_PIX(ACT), .FIELD_LINES(FL), .OUT_W(W), .OUT_H(H)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .vid_byte   (vid_byte),
        .cap_req    (cap_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .frame_done (frame_done)
    );

    // observe outputs shortly after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (mem_we) begin
                wr_cnt++;
                if (int'(mem_addr) < TOT) begin
                    got[mem_addr] = int'(mem_data);
                    hits[mem_addr]++;
                end else begin
                    bad_addr++;
                end
            end
            if (frame_done) begin
                done_cnt++;
                done_at = byte_num;
            end
        end
    end

    function automatic int pix(int seed, int f, int l, int k);
        return 1 + ((seed * 53 + f * 37 + l * 13 + k * 7) % 253);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        wr_cnt = 0; done_cnt = 0; bad_addr = 0; done_at = -1; last_byte = -1;
        for (int i = 0; i < TOT; i++) begin
            got[i] = -1;
            hits[i] = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        vid_byte = b;
        cap_req  = 1'b0;
        byte_num++;
    endtask

    task automatic send_code(input bit f, input bit v, input bit h);
        logic [7:0] xy;
        xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        send_byte(8'hFF);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(xy);
    endtask

    task automatic send_line(input bit f, input bit v, input int seed, input int l,
                             input bit mark, input bit req);
        send_code(f, v, 1'b1);
        for (int i = 0; i < 8; i++) send_byte((i % 2) ? 8'h10 : 8'h80);
        send_code(f, v, 1'b0);
        for (int k = 0; k < 2 * ACT; k++) begin
            send_byte(8'(pix(seed, f, l, k)));
            if (req && k == 0) cap_req = 1'b1;
            if (mark && !v && f && l == V0 + H - 1 && k == 2 * (H0 + W - 1) + 1)
                last_byte = byte_num;
        end
    endtask

    task automatic send_field(input bit f, input int seed, input bit mark, input int req_line);
        send_line(f, 1'b1, seed, 50, 1'b0, 1'b0);
        send_line(f, 1'b1, seed, 51, 1'b0, 1'b0);
        for (int l = 0; l < FL; l++) send_line(f, 1'b0, seed, l, mark, l == req_line);
        send_line(f, 1'b1, seed, 52, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) send_byte(8'h10);
    endtask

    task automatic pulse_req();
        send_byte(8'h10);
        cap_req = 1'b1;
        send_byte(8'h10);
    endtask

    task automatic verify_frame(input int seed);
        int a, b, e;
        for (int r = 0; r < H; r++)
            for (int x = 0; x < W; x++) begin
                e = pix(seed, 1, r + V0, 2 * (x + H0) + 1);
                check(got[r * W + x] == e, "R5/R6/R7 luma", got[r * W + x], e);
            end
        for (int k = 0; k < H / 2; k++)
            for (int c = 0; c < CW; c++)
                for (int p = 0; p < 2; p++) begin
                    a = pix(seed, 1, 2 * k + V0, 4 * (c + H0 / 2) + 2 * p);
                    b = pix(seed, 1, 2 * k + 1 + V0, 4 * (c + H0 / 2) + 2 * p);
                    e = (a + b + 1) / 2;
                    check(got[YS + p * CS + k * CW + c] == e, "R8 chroma",
                          got[YS + p * CS + k * CW + c], e);
                end
        for (int i = 0; i < TOT; i++)
            check(hits[i] == 1, "R9 single write per address", hits[i], 1);
        check(wr_cnt == TOT, "R9 write count", wr_cnt, TOT);
        check(bad_addr == 0, "R9 out-of-frame writes", bad_addr, 0);
        check(done_cnt == 1, "R9 done pulses", done_cnt, 1);
        check(done_at == last_byte, "R10 done latency", done_at, last_byte);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_log();
        repeat (3) @(negedge clk);
        check(mem_we == 1'b0, "R1 reset write strobe", int'(mem_we), 0);
        check(frame_done == 1'b0, "R1 reset done", int'(frame_done), 0);
        rst_n = 1'b1;

        // no request: nothing written
        send_field(1'b0, 1, 1'b0, -1);
        send_field(1'b1, 2, 1'b0, -1);
        check(wr_cnt == 0, "R1 R2 writes without request", wr_cnt, 0);

        // request, then a bottom field that must be skipped
        pulse_req();
        send_field(1'b1, 3, 1'b0, -1);
        check(wr_cnt == 0, "R3 bottom field before top skipped", wr_cnt, 0);
        send_field(1'b0, 4, 1'b0, -1);
        check(wr_cnt == 0, "R3 R4 top field not captured", wr_cnt, 0);
        send_field(1'b1, 5, 1'b1, -1);
        verify_frame(5);

        // request during a top field; extra request mid-capture ignored
        clear_log();
        send_line(1'b0, 1'b0, 6, 0, 1'b0, 1'b1);
        send_field(1'b0, 7, 1'b0, -1);
        send_field(1'b1, 8, 1'b1, V0 + 1);
        verify_frame(8);
        clear_log();
        send_field(1'b0, 9, 1'b0, -1);
        send_field(1'b1, 10, 1'b0, -1);
        check(wr_cnt == 0, "R2 request while busy ignored", wr_cnt, 0);
        check(done_cnt == 0, "R2 no done after ignored request", done_cnt, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule